// File: doc/BRIEF.md
# TDM Time-Slot Insertion Multiplexer

This block sits on a serial TDM output path. In each output slot it forwards a byte from the receive reassembly path, except inside a programmable window of consecutive slots. Inside that window it sends bytes captured from a local serial bus instead. The window is set by a 16-bit control word that holds a first output slot, a slot count and an enable bit. Substitution also needs a global transfer enable, and every slot is gated by a per-slot output enable.

One byte is presented per clock cycle, and a frame pulse marks output slot 0. In every frame the block stores the local-bus bytes of local slots 0 to 31 in a ping-pong buffer. During the next frame it replays local slot k on output slot (first + k) mod 128. The control word goes into a shadow register. It becomes active only at the next start of a frame, so a frame never mixes two settings.

Top module: `tdm_slot_inserter`

## Requirements
- R1: The output slot number is 0 in a cycle where `frame_sync` is high. Otherwise it advances by one per cycle and wraps from 127 to 0. Cycles that wrap to 0 also start a new frame.
- R2: When insertion is active, output slot (S + k) mod 128 carries the `loc_byte` value that was sampled at slot k of the previous frame, for k = 0..N. S is control bits 6:0.
- R3: When control bit 15 is 0 or `xfer_en` is 0 during a slot, that slot carries `rx_byte` unchanged.
- R4: Control bits 14:8 hold the window length minus one. Values above 31 act as 31, so at most 32 slots are replaced.
- R5: `tdm_valid` equals `slot_oe` of the slot. When `slot_oe` is 0, `tdm_out` is 0 regardless of source.
- R6: The result for a slot appears on `tdm_out`/`tdm_valid` two clock cycles after that slot's inputs are sampled.
- R7: `reg_rdata` returns all 16 bits last written, including reserved bit 7. Bit 7 has no effect on the output.
- R8: A write reaches the active settings at the next slot-0 cycle after the write cycle. The frame in progress keeps its previous settings.
- R9: Synchronous reset clears the control word to 0x0000, disables insertion and drives `tdm_valid` and `tdm_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Marks output slot 0 |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word readback |
| xfer_en | input | 1 | Global transfer enable |
| rx_byte | input | 8 | Byte from the receive reassembly path |
| loc_byte | input | 8 | Byte from the local serial bus |
| slot_oe | input | 1 | Output enable for the current slot |
| tdm_out | output | 8 | Output byte |
| tdm_valid | output | 1 | Output byte is driven |

## Verification
The bench uses the default build: 128 slots per frame, 8-bit bytes and a 32-slot window. With these values the windows that start near slot 127 reach the wrap into slot 0, and a length field of 90 reaches the clamp at 32. A short frame, cut by an early `frame_sync`, and writes in the middle of a frame cover the frame-boundary handover. A reference model predicts every slot for fixed and random settings.

// File: rtl/tdm_ins_pkg.sv
package tdm_ins_pkg;
  parameter int CTRL_W = 16;
  parameter int FIELD_W = 7;

  typedef struct packed {
    logic               ena;
    logic [FIELD_W-1:0] len;
    logic               rsv;
    logic [FIELD_W-1:0] first;
  } ins_ctrl_t;
endpackage

// File: rtl/tdm_slot_ctr.sv
module tdm_slot_ctr #(
  parameter int SLOT_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_sync,
  output logic [SLOT_W-1:0] slot,
  output logic              frame_start
);
  logic [SLOT_W-1:0] slot_q;

  always_comb begin
    slot        = frame_sync ? '0 : slot_q + 1'b1;
    frame_start = (slot == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) slot_q <= '1;
    else     slot_q <= slot;
  end
endmodule

// File: rtl/tdm_ins_cfg.sv
module tdm_ins_cfg
  import tdm_ins_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [CTRL_W-1:0]  wdata,
  input  logic               frame_start,
  output logic [CTRL_W-1:0]  shadow,
  output logic               act_ena,
  output logic [FIELD_W-1:0] act_len,
  output logic [FIELD_W-1:0] act_first
);
  ins_ctrl_t          shadow_q;
  logic               ena_q;
  logic [FIELD_W-1:0] len_q;
  logic [FIELD_W-1:0] first_q;

  always_ff @(posedge clk) begin
    if (rst)     shadow_q <= '0;
    else if (wr) shadow_q <= ins_ctrl_t'(wdata);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ena_q   <= 1'b0;
      len_q   <= '0;
      first_q <= '0;
    end else if (frame_start) begin
      ena_q   <= shadow_q.ena;
      len_q   <= shadow_q.len;
      first_q <= shadow_q.first;
    end
  end

  always_comb begin
    shadow    = shadow_q;
    act_ena   = frame_start ? shadow_q.ena   : ena_q;
    act_len   = frame_start ? shadow_q.len   : len_q;
    act_first = frame_start ? shadow_q.first : first_q;
  end
endmodule

// File: rtl/tdm_loc_buf.sv
module tdm_loc_buf #(
  parameter int DEPTH  = 32,
  parameter int BYTE_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0] mem [2*DEPTH];
  logic              bank_q;
  logic              bank;

  assign bank = frame_start ? ~bank_q : bank_q;

  always_ff @(posedge clk) begin
    if (rst) bank_q <= 1'b0;
    else     bank_q <= bank;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[{bank, wr_addr}] <= wr_data;
    rd_data <= mem[{~bank, rd_addr}];
  end
endmodule

// File: rtl/tdm_slot_inserter.sv
module tdm_slot_inserter
  import tdm_ins_pkg::*;
#(
  parameter int SLOT_W  = FIELD_W,
  parameter int BYTE_W  = 8,
  parameter int MAX_WIN = 32,
  localparam int AW     = $clog2(MAX_WIN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_sync,
  input  logic              reg_wr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  input  logic              xfer_en,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] loc_byte,
  input  logic              slot_oe,
  output logic [BYTE_W-1:0] tdm_out,
  output logic              tdm_valid
);
  localparam logic [SLOT_W-1:0] LEN_CAP = SLOT_W'(MAX_WIN - 1);

  logic [SLOT_W-1:0]  slot;
  logic               frame_start;
  logic               act_ena;
  logic [FIELD_W-1:0] act_len;
  logic [FIELD_W-1:0] act_first;
  logic [SLOT_W-1:0]  offs;
  logic [SLOT_W-1:0]  len_c;
  logic               hit;
  logic [BYTE_W-1:0]  buf_rd;
  logic               hit_q;
  logic               oe_q;
  logic [BYTE_W-1:0]  rx_q;

  tdm_slot_ctr #(.SLOT_W(SLOT_W)) u_ctr (
    .clk         (clk),
    .rst         (rst),
    .frame_sync  (frame_sync),
    .slot        (slot),
    .frame_start (frame_start)
  );

  tdm_ins_cfg u_cfg (
    .clk         (clk),
    .rst         (rst),
    .wr          (reg_wr),
    .wdata       (reg_wdata),
    .frame_start (frame_start),
    .shadow      (reg_rdata),
    .act_ena     (act_ena),
    .act_len     (act_len),
    .act_first   (act_first)
  );

  always_comb begin
    offs  = slot - SLOT_W'(act_first);
    len_c = (SLOT_W'(act_len) > LEN_CAP) ? LEN_CAP : SLOT_W'(act_len);
    hit   = act_ena && xfer_en && (offs <= len_c);
  end

  tdm_loc_buf #(.DEPTH(MAX_WIN), .BYTE_W(BYTE_W)) u_buf (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .wr_en       (slot < SLOT_W'(MAX_WIN)),
    .wr_addr     (slot[AW-1:0]),
    .wr_data     (loc_byte),
    .rd_addr     (offs[AW-1:0]),
    .rd_data     (buf_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q     <= 1'b0;
      oe_q      <= 1'b0;
      rx_q      <= '0;
      tdm_out   <= '0;
      tdm_valid <= 1'b0;
    end else begin
      hit_q     <= hit;
      oe_q      <= slot_oe;
      rx_q      <= rx_byte;
      tdm_valid <= oe_q;
      tdm_out   <= !oe_q ? '0 : (hit_q ? buf_rd : rx_q);
    end
  end
endmodule

// File: rtl/tdm_slot_inserter_chk.sv
module tdm_slot_inserter_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [15:0]       reg_wdata,
  input logic [15:0]       reg_rdata,
  input logic              xfer_en,
  input logic [BYTE_W-1:0] rx_byte,
  input logic              slot_oe,
  input logic [BYTE_W-1:0] tdm_out,
  input logic              tdm_valid
);
  logic [1:0] warm;

  always_ff @(posedge clk) begin
    if (rst)             warm <= '0;
    else if (warm != 2'd2) warm <= warm + 1'b1;
  end

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (reg_rdata == '0 && !tdm_valid && tdm_out == '0));

  a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !tdm_valid |-> tdm_out == '0);

  a_r6_valid_latency: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> tdm_valid == $past(slot_oe, 2));

  a_r3_pass_when_off: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2 && !$past(xfer_en, 2) && $past(slot_oe, 2))
      |-> tdm_out == $past(rx_byte, 2));

  a_r7_readback: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> reg_rdata == $past(reg_wdata));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && warm != 2'd0) |=> $stable(reg_rdata));
endmodule

bind tdm_slot_inserter tdm_slot_inserter_chk #(.BYTE_W(BYTE_W)) i_chk (.*);

// File: tb/test_tdm_slot_inserter.sv
module test_tdm_slot_inserter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_sync = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        xfer_en = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic [7:0]  loc_byte = '0;
  logic        slot_oe = 1'b0;
  logic [7:0]  tdm_out;
  logic        tdm_valid;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  tdm_slot_inserter i_tdm_slot_inserter (
    .clk(clk), .rst(rst), .frame_sync(frame_sync), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_en(xfer_en),
    .rx_byte(rx_byte), .loc_byte(loc_byte), .slot_oe(slot_oe),
    .tdm_out(tdm_out), .tdm_valid(tdm_valid)
  );

  // {xfer_en, control word}
  localparam logic [16:0] VEC [8] = '{
    {1'b1, 16'h8305}, {1'b1, 16'h8F78}, {1'b1, 16'h9F64}, {1'b1, 16'hDA80},
    {1'b1, 16'h807F}, {1'b0, 16'h850A}, {1'b1, 16'h050A}, {1'b1, 16'h9F40}
  };

  // reference model state
  logic [6:0]  m_slot;
  logic [15:0] m_shadow, m_act;
  logic [7:0]  m_cur [32];
  logic [7:0]  m_prev [32];
  bit          m_cur_k [32];
  bit          m_prev_k [32];
  bit          d_ok;
  bit          d_skip;
  logic [7:0]  d_byte;
  logic        d_valid;
  string       d_tag;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_slot = 7'h7F; m_shadow = '0; m_act = '0; d_ok = 0;
    for (int i = 0; i < 32; i++) begin m_cur_k[i] = 0; m_prev_k[i] = 0; end
  endtask

  task automatic cyc(input bit sync, input bit wr, input logic [15:0] wd, input bit xen);
    logic [6:0] k, lenc;
    bit hit;
    frame_sync = sync; reg_wr = wr; reg_wdata = wd; xfer_en = xen;
    rx_byte = 8'($urandom); loc_byte = 8'($urandom); slot_oe = ($urandom % 10) != 0;
    m_slot = sync ? 7'd0 : m_slot + 7'd1;
    if (m_slot == 0) begin
      m_act = m_shadow;
      for (int i = 0; i < 32; i++) begin m_prev[i] = m_cur[i]; m_prev_k[i] = m_cur_k[i]; end
    end
    k    = m_slot - m_act[6:0];
    lenc = (m_act[14:8] > 7'd31) ? 7'd31 : m_act[14:8];
    hit  = m_act[15] && xen && (k <= lenc);
    if (m_slot < 32) begin m_cur[m_slot[4:0]] = loc_byte; m_cur_k[m_slot[4:0]] = 1; end
    if (wr) m_shadow = wd;
    @(posedge clk);
    @(negedge clk);
    cycles++;
    if (d_ok && !d_skip) begin
      check({d_tag, " valid"}, 16'(tdm_valid), 16'(d_valid));
      check({d_tag, " byte"}, 16'(tdm_out), 16'(d_byte));
    end
    d_ok    = 1;
    d_valid = slot_oe;
    d_skip  = slot_oe && hit && !m_prev_k[k[4:0]];
    d_byte  = !slot_oe ? 8'h00 : (hit ? m_prev[k[4:0]] : rx_byte);
    d_tag   = !slot_oe ? "R5 R6" : (hit ? "R2 R4 R7 R8" : "R1 R3 R6");
  endtask

  task automatic do_reset();
    rst = 1'b1; reg_wr = 0; frame_sync = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  task automatic run_frame(input int len, input int wr_at, input logic [15:0] wd, input bit xen);
    for (int s = 0; s < len; s++) cyc(s == 0, s == wr_at, wd, xen);
  endtask

  initial begin
    while (cycles < 150000) @(negedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R9: reset state at the ports
    check("R9 rdata", reg_rdata, 16'h0000);
    check("R9 valid", 16'(tdm_valid), 16'h0);
    check("R9 out", 16'(tdm_out), 16'h0);

    run_frame(128, -1, 16'h0, 1'b1);
    for (int v = 0; v < 8; v++) begin
      for (int f = 0; f < 3; f++) run_frame(128, (f == 0) ? 60 : -1, VEC[v][15:0], VEC[v][16]);
      check("R7 readback", reg_rdata, VEC[v][15:0]);
    end

    // R1: short frame cut by an early frame_sync, window wrapping past 127
    run_frame(128, 10, 16'h8F78, 1'b1);
    run_frame(128, -1, 16'h0, 1'b1);
    run_frame(70, -1, 16'h0, 1'b1);
    run_frame(128, -1, 16'h0, 1'b1);
    // R1: free-running wrap without frame_sync
    for (int s = 0; s < 200; s++) cyc(1'b0, 1'b0, 16'h0, 1'b1);

    // R8: write in mid-frame keeps the running frame on the old setting
    run_frame(128, 5, 16'h8A00, 1'b1);
    run_frame(128, 100, 16'h9F70, 1'b1);
    run_frame(128, -1, 16'h0, 1'b1);

    // random settings including wrapping windows
    for (int r = 0; r < 6; r++) begin
      logic [15:0] w;
      w = 16'($urandom) & 16'hFF7F;
      w[15] = 1'b1;
      if (r % 2 == 0) w[6:0] = 7'd110 + 7'(r);
      for (int f = 0; f < 2; f++) run_frame(128, (f == 0) ? 3 : -1, w, 1'b1);
    end

    // R9: reset during operation
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 rdata mid", reg_rdata, 16'h0000);
    check("R9 valid mid", 16'(tdm_valid), 16'h0);
    rst = 1'b0;
    model_clear();
    run_frame(128, -1, 16'h0, 1'b1);
    run_frame(128, -1, 16'h0, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule